// File: doc/BRIEF.md
# USB Endpoint Ping-Pong Buffer Status Controller

This block holds the control and status state for one non-control USB function endpoint whose packet storage is a pair of buffer halves. At any time the CPU owns one half and the host-side serial engine owns the other. The block tracks which half each side owns. It raises a data request when a packet needs CPU attention, and it swaps ownership when software acknowledges that request. For the IN direction it also reports each packet that the CPU side commits, including zero-length packets.

Software reaches the block through a single status/control register. It can reset the buffer pair, acknowledge requests, clear the short-packet flag and enable two interrupt sources. The host side reports a finished packet with a one-cycle strobe and a byte count, and it holds a busy level while it is using its half. The buffer RAM, the serial engine and any DMA engine sit outside this block. DMA mode reaches the block only as one input bit.

Top module: `ep_dbuf_ctrl`

## Requirements
- R1: While the init bit reads 1 and `host_busy_i` is low, every clock edge clears the request and short-packet flags, gives the CPU half 0 (`cpu_buf_o`=0) and clears the CPU byte count.
- R2: While `ctrl_rst_i` is high the init bit is forced to 1, and a register write of 0 to it has no effect. After `ctrl_rst_i` is released, a write of 0 clears it.
- R3: A `host_done_i` strobe sets the request flag on that edge, unless the init bit is in effect.
- R4: A register write with the request bit (bit 0) equal to 1 never sets the request flag.
- R5: A register write with bit 0 equal to 0 while the request flag is 1 clears the flag, toggles `cpu_buf_o` (with `host_buf_o` always its inverse) and resets the CPU byte count to 0.
- R6: A register write with bit 0 equal to 0 while the request flag is already 0 is ignored. No buffer swap and no commit follow.
- R7: With `dir_in_i`=1, a valid acknowledge pulses `commit_o` for one cycle on the next cycle, with `commit_len_o` holding the CPU byte count. `zlp_o` pulses with it when that count was 0. Each `cpu_wr_i` strobe adds one to the count, which saturates at MAX_PKT.
- R8: When `dir_in_i` goes from 0 to 1, the request flag reads 1 after the first edge that samples the new value.
- R9: The busy bit (bit 2) is read-only and shows the value of `host_busy_i` at the previous edge. Writes do not affect it.
- R10: A `host_done_i` with `host_cnt_i` < MAX_PKT sets the short-packet flag (bit 1). A write with bit 1 equal to 0 clears the flag, and a write with bit 1 equal to 1 leaves it unchanged.
- R11: `irq_o` = (request AND request-enable (bit 4) AND NOT `dma_mode_i`) OR (short AND short-enable (bit 5)).
- R12: If the init bit is set while `host_busy_i` is high, the buffer reset of R1 waits and takes effect on the first edge at which `host_busy_i` is low.
- R13: After `rst_ni` the register reads 0x08: only the init bit (bit 3) is set, and `cpu_buf_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_rst_i | input | 1 | Controller-level reset, forces the init bit |
| dir_in_i | input | 1 | Endpoint direction, 1 = IN |
| dma_mode_i | input | 1 | DMA mode, masks the request interrupt |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| cpu_wr_i | input | 1 | CPU wrote one byte into its half |
| host_done_i | input | 1 | Host-side packet finished (one cycle) |
| host_cnt_i | input | CNT_W | Byte count of the finished packet |
| host_busy_i | input | 1 | Host side is accessing its half |
| cpu_buf_o | output | 1 | Index of the half owned by the CPU |
| host_buf_o | output | 1 | Index of the half owned by the host |
| cpu_cnt_o | output | CNT_W | Bytes the CPU has written into its half |
| commit_o | output | 1 | IN packet committed (one cycle) |
| commit_len_o | output | CNT_W | Length of the committed packet |
| zlp_o | output | 1 | Committed packet has zero length |
| irq_o | output | 1 | Endpoint interrupt request |

## Verification
The assertions assume that `host_done_i` is a single-cycle strobe and that `host_busy_i` is a level that the host side holds only while it uses its own half. They also assume that software never acknowledges in the same cycle as a done strobe. The stimulus drives every input on the falling clock edge, raises each strobe for exactly one edge, and keeps acknowledges, done strobes and direction changes in separate cycles. The only deliberate overlaps are an init request under busy and register writes under controller reset.

// File: rtl/ep_dbuf_pkg.sv
package ep_dbuf_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned F_REQ    = 0;
  localparam int unsigned F_SPK    = 1;
  localparam int unsigned F_BUSY   = 2;
  localparam int unsigned F_INIT   = 3;
  localparam int unsigned F_REQ_IE = 4;
  localparam int unsigned F_SPK_IE = 5;

  typedef struct packed {
    logic req;
    logic spk;
    logic busy;
    logic init;
    logic req_ie;
    logic spk_ie;
  } ep_flags_t;
endpackage

// File: rtl/ep_dbuf_regs.sv
module ep_dbuf_regs
  import ep_dbuf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_rst_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic             host_done_i,
  input  logic             host_short_i,
  input  logic             host_busy_i,
  input  logic             dir_rise_i,
  output ep_flags_t        flags_o,
  output logic             init_eff_o,
  output logic             swap_o
);
  ep_flags_t f_q;

  // init acts only when host side is idle; otherwise it stays pending
  assign init_eff_o = f_q.init & ~host_busy_i;
  assign swap_o     = reg_wr_i & ~reg_wdata_i[F_REQ] & f_q.req & ~init_eff_o;
  assign flags_o    = f_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_q      <= '0;
      f_q.init <= 1'b1;
    end else begin
      f_q.busy <= host_busy_i;

      if (ctrl_rst_i)    f_q.init <= 1'b1;
      else if (reg_wr_i) f_q.init <= reg_wdata_i[F_INIT];

      if (reg_wr_i) begin
        f_q.req_ie <= reg_wdata_i[F_REQ_IE];
        f_q.spk_ie <= reg_wdata_i[F_SPK_IE];
      end

      if (init_eff_o)                     f_q.req <= 1'b0;
      else if (host_done_i || dir_rise_i) f_q.req <= 1'b1;
      else if (swap_o)                    f_q.req <= 1'b0;

      if (init_eff_o)                          f_q.spk <= 1'b0;
      else if (host_done_i && host_short_i)    f_q.spk <= 1'b1;
      else if (reg_wr_i && !reg_wdata_i[F_SPK]) f_q.spk <= 1'b0;
    end
  end
endmodule

// File: rtl/ep_dbuf_pingpong.sv
module ep_dbuf_pingpong #(
  parameter int unsigned MAX_PKT = 64,
  localparam int unsigned CNT_W  = $clog2(MAX_PKT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             swap_i,
  input  logic             dir_in_i,
  input  logic             cpu_wr_i,
  output logic             cpu_buf_o,
  output logic [CNT_W-1:0] cpu_cnt_o,
  output logic             commit_o,
  output logic [CNT_W-1:0] commit_len_o,
  output logic             zlp_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PKT);

  logic             buf_q;
  logic [CNT_W-1:0] cnt_q;

  assign cpu_buf_o = buf_q;
  assign cpu_cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q        <= 1'b0;
      cnt_q        <= '0;
      commit_o     <= 1'b0;
      commit_len_o <= '0;
      zlp_o        <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      zlp_o    <= 1'b0;
      if (init_i) begin
        buf_q <= 1'b0;
        cnt_q <= '0;
      end else if (swap_i) begin
        buf_q <= ~buf_q;
        cnt_q <= '0;
        if (dir_in_i) begin
          commit_o     <= 1'b1;
          commit_len_o <= cnt_q;
          zlp_o        <= (cnt_q == '0);
        end
      end else if (cpu_wr_i && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ep_dbuf_irq.sv
module ep_dbuf_irq
  import ep_dbuf_pkg::*;
(
  input  ep_flags_t flags_i,
  input  logic      dma_mode_i,
  output logic      irq_o
);
  localparam int unsigned N_SRC = 2;
  logic [N_SRC-1:0] src;
  logic [N_SRC-1:0] en;

  assign src = {flags_i.spk, flags_i.req};
  assign en  = {flags_i.spk_ie, flags_i.req_ie & ~dma_mode_i};

  logic [N_SRC-1:0] hit;
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = src[i] & en[i];
  end
  assign irq_o = |hit;
endmodule

// File: rtl/ep_dbuf_ctrl.sv
module ep_dbuf_ctrl
  import ep_dbuf_pkg::*;
#(
  parameter int unsigned MAX_PKT = 64,
  localparam int unsigned CNT_W  = $clog2(MAX_PKT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_rst_i,
  input  logic             dir_in_i,
  input  logic             dma_mode_i,
  input  logic             reg_wr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic             cpu_wr_i,
  input  logic             host_done_i,
  input  logic [CNT_W-1:0] host_cnt_i,
  input  logic             host_busy_i,
  output logic             cpu_buf_o,
  output logic             host_buf_o,
  output logic [CNT_W-1:0] cpu_cnt_o,
  output logic             commit_o,
  output logic [CNT_W-1:0] commit_len_o,
  output logic             zlp_o,
  output logic             irq_o
);
  ep_flags_t flags;
  logic      init_eff, swap, dir_q, dir_rise, host_short;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= 1'b0;
    else         dir_q <= dir_in_i;
  end
  assign dir_rise   = dir_in_i & ~dir_q;
  assign host_short = host_cnt_i < CNT_W'(MAX_PKT);

  ep_dbuf_regs u_regs (
    .clk_i, .rst_ni, .ctrl_rst_i, .reg_wr_i, .reg_wdata_i, .host_done_i,
    .host_short_i (host_short),
    .host_busy_i,
    .dir_rise_i   (dir_rise),
    .flags_o      (flags),
    .init_eff_o   (init_eff),
    .swap_o       (swap)
  );

  ep_dbuf_pingpong #(.MAX_PKT(MAX_PKT)) u_pp (
    .clk_i, .rst_ni,
    .init_i   (init_eff),
    .swap_i   (swap),
    .dir_in_i, .cpu_wr_i, .cpu_buf_o, .cpu_cnt_o, .commit_o, .commit_len_o, .zlp_o
  );

  ep_dbuf_irq u_irq (.flags_i(flags), .dma_mode_i, .irq_o);

  assign host_buf_o = ~cpu_buf_o;

  always_comb begin
    reg_rdata_o           = '0;
    reg_rdata_o[F_REQ]    = flags.req;
    reg_rdata_o[F_SPK]    = flags.spk;
    reg_rdata_o[F_BUSY]   = flags.busy;
    reg_rdata_o[F_INIT]   = flags.init;
    reg_rdata_o[F_REQ_IE] = flags.req_ie;
    reg_rdata_o[F_SPK_IE] = flags.spk_ie;
  end
endmodule

// File: rtl/ep_dbuf_chk.sv
module ep_dbuf_chk
  import ep_dbuf_pkg::*;
#(
  parameter int unsigned MAX_PKT = 64,
  localparam int unsigned CNT_W  = $clog2(MAX_PKT + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_rst_i,
  input logic             dma_mode_i,
  input logic             reg_wr_i,
  input logic [7:0]       reg_wdata_i,
  input logic [7:0]       reg_rdata_o,
  input logic             host_done_i,
  input logic             host_busy_i,
  input logic             cpu_buf_o,
  input logic [CNT_W-1:0] cpu_cnt_o,
  input logic             commit_o,
  input logic [CNT_W-1:0] commit_len_o,
  input logic             zlp_o,
  input logic             irq_o,
  input logic             dir_rise
);
  a_r1_init_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[F_INIT] && !host_busy_i |=>
      !reg_rdata_o[F_REQ] && !reg_rdata_o[F_SPK] && !cpu_buf_o && cpu_cnt_o == '0);

  a_r2_init_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_i |=> reg_rdata_o[F_INIT]);

  a_r3_done_sets_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_done_i && !reg_rdata_o[F_INIT] |=> reg_rdata_o[F_REQ]);

  a_r4_write_one_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_wdata_i[F_REQ] && !reg_rdata_o[F_REQ] && !host_done_i && !dir_rise
      |=> !reg_rdata_o[F_REQ]);

  a_r6_illegal_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && !reg_wdata_i[F_REQ] && !reg_rdata_o[F_REQ] && !reg_rdata_o[F_INIT]
      |=> $stable(cpu_buf_o) && !commit_o);

  a_r7_zlp_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zlp_o |-> commit_o && commit_len_o == '0);

  a_r9_busy_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_busy_i |=> reg_rdata_o[F_BUSY]);

  a_r9_busy_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_busy_i |=> !reg_rdata_o[F_BUSY]);

  a_r11_dma_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_mode_i && !reg_rdata_o[F_SPK] |-> !irq_o);
endmodule

bind ep_dbuf_ctrl ep_dbuf_chk #(.MAX_PKT(MAX_PKT)) u_chk (.*);

// File: tb/sim_ep_dbuf_ctrl.sv
`timescale 1ns/1ps
module sim_ep_dbuf_ctrl;
  localparam int unsigned MAX_PKT = 64;
  localparam int unsigned CNT_W   = $clog2(MAX_PKT + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_rst = 0, dir_in = 0, dma = 0, wr = 0, cpu_wr = 0, done = 0, busy = 0;
  logic [7:0]       wd = '0;
  logic [7:0]       rd;
  logic [CNT_W-1:0] hcnt = '0, ccnt, clen;
  logic cbuf, hbuf, commit, zlp, irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ep_dbuf_ctrl #(.MAX_PKT(MAX_PKT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_rst_i(ctrl_rst), .dir_in_i(dir_in),
    .dma_mode_i(dma), .reg_wr_i(wr), .reg_wdata_i(wd), .reg_rdata_o(rd),
    .cpu_wr_i(cpu_wr), .host_done_i(done), .host_cnt_i(hcnt), .host_busy_i(busy),
    .cpu_buf_o(cbuf), .host_buf_o(hbuf), .cpu_cnt_o(ccnt), .commit_o(commit),
    .commit_len_o(clen), .zlp_o(zlp), .irq_o(irq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns after the capturing rising edge
  task automatic step(logic w, logic [7:0] d, logic dn, int hc, logic cw, logic dr, logic bz);
    @(negedge clk);
    wr = w; wd = d; done = dn; hcnt = CNT_W'(hc); cpu_wr = cw; dir_in = dr; busy = bz;
    @(posedge clk);
    #1;
  endtask

  typedef struct packed {
    logic       w;
    logic [7:0] d;
    logic       dn;
    logic [6:0] hc;
    logic       dr;
    logic       e_req;
    logic       e_spk;
    logic       e_buf;
  } vec_t;

  // 0x33 = enables on, req/spk bits 1 (no clear); 0x32 acks; 0x31 clears short
  localparam vec_t VEC [9] = '{
    '{1'b1, 8'h33, 1'b0, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b1, 7'd64, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'h32, 1'b0, 7'd0,  1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b1, 7'd10, 1'b0, 1'b1, 1'b1, 1'b1},
    '{1'b1, 8'h31, 1'b0, 7'd0,  1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b1, 8'h32, 1'b0, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'h32, 1'b0, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'h33, 1'b0, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 7'd0,  1'b1, 1'b1, 1'b0, 1'b0}
  };
  localparam string VTAG [9] = '{"R2", "R3", "R5", "R10", "R10", "R5", "R6", "R4", "R8"};

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R13 reset reg", int'(rd), 8'h08);
    check("R13 reset buf", int'(cbuf), 0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      step(VEC[i].w, VEC[i].d, VEC[i].dn, int'(VEC[i].hc), 1'b0, VEC[i].dr, 1'b0);
      check({VTAG[i], " req"}, int'(rd[0]), int'(VEC[i].e_req));
      check({VTAG[i], " spk"}, int'(rd[1]), int'(VEC[i].e_spk));
      check({VTAG[i], " buf"}, int'(cbuf), int'(VEC[i].e_buf));
      check({VTAG[i], " hbuf"}, int'(hbuf), int'(!VEC[i].e_buf));
    end
    check("R6 no commit", int'(commit), 0);
    check("R11 req irq", int'(irq), 1);
    @(negedge clk) dma = 1'b1;
    #1 check("R11 dma mask", int'(irq), 0);
    @(negedge clk) dma = 1'b0;

    // R7: three bytes then ack in IN
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b0, 0, 1'b1, 1'b1, 1'b0);
    check("R7 count", int'(ccnt), 3);
    step(1'b1, 8'h32, 1'b0, 0, 1'b0, 1'b1, 1'b0);
    check("R7 commit", int'(commit), 1);
    check("R7 len", int'(clen), 3);
    check("R7 zlp", int'(zlp), 0);
    check("R5 swap", int'(cbuf), 1);
    check("R5 cnt reset", int'(ccnt), 0);
    step(1'b0, 8'h00, 1'b0, 0, 1'b0, 1'b1, 1'b0);
    check("R7 pulse", int'(commit), 0);
    step(1'b0, 8'h00, 1'b1, 64, 1'b0, 1'b1, 1'b0);
    step(1'b1, 8'h32, 1'b0, 0, 1'b0, 1'b1, 1'b0);
    check("R7 zlp commit", int'(commit), 1);
    check("R7 zlp", int'(zlp), 1);
    check("R7 zlp len", int'(clen), 0);
    check("R5 swap back", int'(cbuf), 0);

    // R10/R11 short irq, R9 busy
    step(1'b1, 8'h20, 1'b1, 5, 1'b0, 1'b1, 1'b1);
    check("R10 short set", int'(rd[1]), 1);
    check("R11 spk irq", int'(irq), 1);
    check("R9 busy", int'(rd[2]), 1);
    step(1'b1, 8'h37, 1'b0, 0, 1'b0, 1'b1, 1'b0);
    check("R9 busy ro", int'(rd[2]), 0);

    // R12: init under busy is pending (req=1, spk=1, buf=0 now; get buf=1)
    step(1'b1, 8'h33, 1'b0, 0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 8'h32, 1'b0, 0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b1, 64, 1'b0, 1'b1, 1'b0);
    check("R12 pre buf", int'(cbuf), 1);
    step(1'b1, 8'h3B, 1'b0, 0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 8'h00, 1'b0, 0, 1'b0, 1'b1, 1'b1);
    check("R12 held req", int'(rd[0]), 1);
    check("R12 held buf", int'(cbuf), 1);
    step(1'b0, 8'h00, 1'b0, 0, 1'b0, 1'b1, 1'b0);
    check("R12 applied req", int'(rd[0]), 0);
    check("R1 applied buf", int'(cbuf), 0);
    check("R1 applied spk", int'(rd[1]), 0);

    // R2: controller reset forces init
    @(negedge clk) ctrl_rst = 1'b1;
    step(1'b1, 8'h33, 1'b0, 0, 1'b0, 1'b1, 1'b0);
    check("R2 forced", int'(rd[3]), 1);
    @(negedge clk) ctrl_rst = 1'b0;
    step(1'b1, 8'h33, 1'b0, 0, 1'b0, 1'b1, 1'b0);
    check("R2 released", int'(rd[3]), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule